// File: doc/BRIEF.md
# Memory protection access decision unit

This block gives the final allow-or-fault verdict for every memory access of a processor core. Region comparators elsewhere compare the access address with the configured regions and deliver a hit flag, a permission result and an execute-never bit. This block combines those inputs with its own three-bit control word and the attributes of the access. The attributes are the address, privileged or user mode, instruction fetch or data access, a vector-table load flag and the signed execution priority. It returns a registered fault flag and the effective execute-never attribute one clock after the request.

Three policies sit on top of the region result. A privileged-only background map stands below all configured regions. At the escalated priorities -1 and -2 protection is bypassed unless it has been explicitly kept on. A system partition at the top eighth of the address space is always reachable for data, but an instruction fetch there always faults. Software reaches the control word through a small single-cycle register port at one fixed offset.

Top module: `mpu_access_guard`

## Requirements
- R1: The control word sits at register offset `CTRL_OFS` (default 0x94). Bit 0 is the protection enable, bit 1 keeps protection active at escalated priority, and bit 2 enables the privileged background map. All three bits reset to 0, the upper read bits are 0, and any other offset reads 0. A write affects accesses presented from the next cycle onward, so an access presented in the same cycle as the write is judged with the old word.
- R2: With bit 0 clear, no access faults except an instruction fetch to the system partition.
- R3: With bit 1 clear, an access at priority -1 or -2 is judged as if protection were off, whatever bit 0 holds.
- R4: With bits 0 and 1 set, protection stays active at priority -1 and -2.
- R5: With protection active, an access with the region-hit flag set outside the system partition, and not a vector load, faults when the region permission is 0 or when it is a fetch with the region execute-never set. It is allowed otherwise.
- R6: With protection active and bit 2 clear, an access that hits no region faults.
- R7: With protection active and bit 2 set, an unmatched privileged access (fetch or data) is allowed and an unmatched user access faults.
- R8: With protection active, data accesses to the system partition and vector-table loads are allowed whatever the region inputs say.
- R9: Addresses 0xE000_0000 to 0xFFFF_FFFF (top three address bits all 1) always report execute-never, and an instruction fetch there faults in every configuration.
- R10: With bit 1 set and bit 0 clear, protection is off.
- R11: The result valid, fault and execute-never outputs are registered. They reflect the access presented one clock earlier and read 0 after a cycle with no access. Outside the system partition, execute-never is the region execute-never bit only when protection is active and a region hits, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational from reg_addr) |
| acc_valid | input | 1 | Access request present |
| acc_addr | input | AW | Access address |
| acc_priv | input | 1 | 1 = privileged mode |
| acc_fetch | input | 1 | 1 = instruction fetch, 0 = data |
| acc_vec | input | 1 | Vector-table load |
| acc_prio | input | PRIO_W | Signed current execution priority |
| rgn_hit | input | 1 | Some configured region matched |
| rgn_allow | input | 1 | Permission result of the matching region |
| rgn_xn | input | 1 | Execute-never of the matching region |
| res_valid | output | 1 | Result valid, one cycle after acc_valid |
| res_fault | output | 1 | Access faults |
| res_xn | output | 1 | Effective execute-never |

## Verification
A write to the control word and an access decision can fall in the same cycle. The bench provokes this by presenting an unmatched user access in the very cycle that switches protection on. It expects the old, disabled verdict, then repeats the access one cycle later and expects a fault. The escalated-priority bypass and the system-partition rule also overlap on a single access. The full sweep over every control value, every priority class and addresses on both sides of the partition edge judges that overlap against an arithmetic model.

// File: rtl/mpu_guard_pkg.sv
package mpu_guard_pkg;

    localparam int CTRL_BITS = 3;

    // bit 2: background map, bit 1: keep on when escalated, bit 0: enable
    typedef struct packed {
        logic bg_priv;
        logic esc_on;
        logic prot_on;
    } guard_ctrl_t;

    typedef struct packed {
        logic valid;
        logic fault;
        logic xn;
    } guard_res_t;

endpackage

// File: rtl/mpu_ctrl_reg.sv
module mpu_ctrl_reg
    import mpu_guard_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h94
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output guard_ctrl_t       ctrl
);

    guard_ctrl_t ctrl_d, ctrl_q;
    logic        hit_ofs;

    assign hit_ofs = (reg_addr == CTRL_OFS);

    always_comb begin
        ctrl_d = ctrl_q;
        if (reg_wr && hit_ofs) begin
            ctrl_d = guard_ctrl_t'(reg_wdata[CTRL_BITS-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (hit_ofs) reg_rdata[CTRL_BITS-1:0] = ctrl_q;
    end

    assign ctrl = ctrl_q;

    // R1
    wr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && hit_ofs) |=> (ctrl == $past(reg_wdata[CTRL_BITS-1:0])));

    // R1
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && hit_ofs) |=> $stable(ctrl));

endmodule

// File: rtl/mpu_decide.sv
module mpu_decide
    import mpu_guard_pkg::*;
#(
    parameter int AW       = 32,
    parameter int PRIO_W   = 9,
    parameter int SYS_BITS = 3
) (
    input  guard_ctrl_t              ctrl,
    input  logic [AW-1:0]            addr,
    input  logic                     priv,
    input  logic                     fetch,
    input  logic                     vec,
    input  logic signed [PRIO_W-1:0] prio,
    input  logic                     hit,
    input  logic                     allow,
    input  logic                     rxn,
    output logic                     fault,
    output logic                     xn
);

    localparam logic [PRIO_W-1:0] PRIO_M1 = '1;
    localparam logic [PRIO_W-1:0] PRIO_M2 = {{(PRIO_W-1){1'b1}}, 1'b0};

    logic escalated, active, in_sys;

    assign escalated = (prio == PRIO_M1) || (prio == PRIO_M2);
    assign active    = ctrl.prot_on && !(escalated && !ctrl.esc_on);
    assign in_sys    = &addr[AW-1 -: SYS_BITS];

    always_comb begin
        fault = 1'b0;
        xn    = 1'b0;
        if (in_sys) begin
            xn    = 1'b1;
            fault = fetch;
        end else if (active && !vec) begin
            if (hit) begin
                xn    = rxn;
                fault = !allow || (fetch && rxn);
            end else begin
                fault = !(ctrl.bg_priv && priv);
            end
        end else if (active && hit) begin
            xn = rxn;
        end
    end

endmodule

// File: rtl/mpu_access_guard.sv
module mpu_access_guard
    import mpu_guard_pkg::*;
#(
    parameter int AW       = 32,
    parameter int PRIO_W   = 9,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int SYS_BITS = 3,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h94
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata,
    input  logic                     acc_valid,
    input  logic [AW-1:0]            acc_addr,
    input  logic                     acc_priv,
    input  logic                     acc_fetch,
    input  logic                     acc_vec,
    input  logic signed [PRIO_W-1:0] acc_prio,
    input  logic                     rgn_hit,
    input  logic                     rgn_allow,
    input  logic                     rgn_xn,
    output logic                     res_valid,
    output logic                     res_fault,
    output logic                     res_xn
);

    guard_ctrl_t ctrl;
    guard_res_t  res_d, res_q;
    logic        dec_fault, dec_xn;

    mpu_ctrl_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_OFS(CTRL_OFS)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ctrl      (ctrl)
    );

    mpu_decide #(.AW(AW), .PRIO_W(PRIO_W), .SYS_BITS(SYS_BITS)) u_dec (
        .ctrl  (ctrl),
        .addr  (acc_addr),
        .priv  (acc_priv),
        .fetch (acc_fetch),
        .vec   (acc_vec),
        .prio  (acc_prio),
        .hit   (rgn_hit),
        .allow (rgn_allow),
        .rxn   (rgn_xn),
        .fault (dec_fault),
        .xn    (dec_xn)
    );

    always_comb begin
        res_d.valid = acc_valid;
        res_d.fault = acc_valid && dec_fault;
        res_d.xn    = acc_valid && dec_xn;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid = res_q.valid;
    assign res_fault = res_q.fault;
    assign res_xn    = res_q.xn;

    logic sys_a, sys_fetch_a;
    assign sys_a       = &acc_addr[AW-1 -: SYS_BITS];
    assign sys_fetch_a = sys_a && acc_fetch;

    // R11
    lat_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> res_valid);

    // R11
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!res_valid && !res_fault && !res_xn));

    // R9
    sys_xn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && sys_a) |=> (res_xn && (res_fault == $past(acc_fetch))));

    // R2
    off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !ctrl.prot_on && !sys_fetch_a) |=> !res_fault);

    // R8
    vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_vec && !sys_fetch_a) |=> !res_fault);

endmodule

// File: tb/sim_mpu_access_guard.sv
module sim_mpu_access_guard;

    localparam int AW = 32;
    localparam int PW = 9;
    localparam logic [7:0] OFS = 8'h94;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [7:0] reg_addr = OFS;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic acc_valid = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic acc_priv = 1'b0, acc_fetch = 1'b0, acc_vec = 1'b0;
    logic signed [PW-1:0] acc_prio = '0;
    logic rgn_hit = 1'b0, rgn_allow = 1'b0, rgn_xn = 1'b0;
    logic res_valid, res_fault, res_xn;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    mpu_access_guard u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_priv(acc_priv), .acc_fetch(acc_fetch),
        .acc_vec(acc_vec), .acc_prio(acc_prio), .rgn_hit(rgn_hit),
        .rgn_allow(rgn_allow), .rgn_xn(rgn_xn), .res_valid(res_valid),
        .res_fault(res_fault), .res_xn(res_xn)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reference model computed from the requirement text
    task automatic model(input logic [2:0] c, input logic [31:0] a, input logic pv,
                         input logic fe, input logic ve, input int pr, input logic h,
                         input logic al, input logic rx, output logic ef,
                         output logic ex, output string tag);
        logic on, sys;
        sys = (a >= 32'hE000_0000);
        on  = c[0] && !((pr == -1 || pr == -2) && !c[1]);
        ef = 1'b0; ex = 1'b0;
        if (!c[0])                         tag = (c[1]) ? "R10" : "R2";
        else if (pr == -1 || pr == -2)     tag = c[1] ? "R4" : "R3";
        else                               tag = "R5";
        if (sys) begin
            ex = 1'b1; ef = fe; tag = "R9";
        end else if (on) begin
            if (h) ex = rx;
            if (ve) begin
                ef = 1'b0; tag = "R8";
            end else if (h) begin
                ef = !al || (fe && rx);
            end else if (!c[2]) begin
                ef = 1'b1; tag = "R6";
            end else begin
                ef = !pv; tag = "R7";
            end
        end
    endtask

    task automatic wr_ctrl(input logic [2:0] v);
        reg_wr = 1'b1; reg_addr = OFS; reg_wdata = {29'h1ABCDEF0, v};
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] addrs [4];
        int prios [5];
        logic ef, ex;
        string tag;
        addrs[0] = 32'h2000_0000; addrs[1] = 32'hDFFF_FFFC;
        addrs[2] = 32'hE000_0000; addrs[3] = 32'hFFFF_FFFF;
        prios[0] = 0; prios[1] = -1; prios[2] = -2; prios[3] = -3; prios[4] = 5;

        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1", reg_rdata, 32'h0);
        chk("R11", {29'h0, res_valid, res_fault, res_xn}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 other offset reads zero
        wr_ctrl(3'b111);
        reg_addr = 8'h90;
        #1 chk("R1", reg_rdata, 32'h0);
        reg_addr = OFS;
        #1 chk("R1", reg_rdata, 32'h7);

        // R1 same-cycle write and access: old word governs
        wr_ctrl(3'b000);
        acc_valid = 1'b1; acc_addr = 32'h1000_0000; acc_priv = 1'b0;
        acc_fetch = 1'b0; acc_vec = 1'b0; acc_prio = 9'sd0; rgn_hit = 1'b0;
        reg_wr = 1'b1; reg_wdata = 32'h1;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R1", {31'h0, res_fault}, 32'h0);
        @(negedge clk);
        chk("R6", {31'h0, res_fault}, 32'h1);
        acc_valid = 1'b0;
        @(negedge clk);
        chk("R11", {29'h0, res_valid, res_fault, res_xn}, 32'h0);

        for (int c = 0; c < 8; c++) begin
            wr_ctrl(c[2:0]);
            chk("R1", reg_rdata, c);
            for (int ai = 0; ai < 4; ai++) begin
                for (int pi = 0; pi < 5; pi++) begin
                    for (int b = 0; b < 64; b++) begin
                        acc_valid = 1'b1; acc_addr = addrs[ai];
                        acc_prio = PW'(prios[pi]);
                        {acc_priv, acc_fetch, acc_vec, rgn_hit, rgn_allow, rgn_xn} = b[5:0];
                        model(c[2:0], addrs[ai], b[5], b[4], b[3], prios[pi], b[2], b[1], b[0],
                              ef, ex, tag);
                        @(negedge clk);
                        chk("R11", {31'h0, res_valid}, 32'h1);
                        chk(tag, {31'h0, res_fault}, {31'h0, ef});
                        chk((ai >= 2) ? "R9" : "R11", {31'h0, res_xn}, {31'h0, ex});
                    end
                end
            end
        end
        acc_valid = 1'b0;
        @(negedge clk);
        chk("R11", {31'h0, res_valid}, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule